// File: doc/BRIEF.md
# Per-Thread Hammer-Likelihood Request Throttler

This block sits next to a memory request scheduler and measures, for each requesting thread, how strongly its row-activation stream looks like a hammering attack. Each activation that the scheduler issues arrives tagged with its thread, its bank, and a flag. The flag marks whether the target row is already on the blacklist. For every bank and thread pair the block counts the activations to blacklisted rows. The largest per-bank count of a thread is normalized to the most activations a row can legally receive in an epoch, which gives a fixed-point likelihood in the range 0 to 1.

The likelihood sets a cap on how many requests that thread may have in flight. At zero the full hardware ceiling of in-flight requests is available. As the likelihood rises the cap shrinks in proportion, and at one the thread gets no new requests at all. The scheduler reports every request it issues and every request that completes. The block answers with one allow bit per thread. The likelihood values are also driven out so that software can read them as an attack indicator.

Each pair keeps two interleaved counters. Both counters count, and only one of them is read. An epoch tick clears the one being read and hands the read role to the other, which has been counting for a full epoch. The index therefore always covers between one and two epochs of history.

Top module: `hammer_throttle`

## Requirements
- R1: After reset every thread's likelihood is 0 and every thread's allow bit is 1.
- R2: An activation with `act_valid` and `act_blacklisted` both high adds one to both counters of the addressed (thread, bank) pair. An activation with either signal low changes no counter.
- R3: Each counter saturates at `MAX_ACTS`, so a likelihood never exceeds 1.0, which is encoded as `2**FRAC_W`.
- R4: A thread's likelihood, on its `FRAC_W+1`-bit field of `likelihood` (thread t at bits `t*(FRAC_W+1)` upward), equals floor(peak × 2**FRAC_W / MAX_ACTS). Here peak is the largest read-side count of that thread over all banks. It updates in the cycle after the activation edge.
- R5: `epoch_tick` clears the counter currently being read in every pair and hands the read role to its partner. A blacklisted activation in the same cycle is counted only by the partner. After a tick the likelihood reflects only the activations since the previous tick.
- R6: A thread's quota is floor(MAX_INFLIGHT × (2**FRAC_W − likelihood) / 2**FRAC_W). `req_allow[t]` is 1 exactly when that thread's outstanding count is below its quota.
- R7: A thread's outstanding count rises by one on `req_issue[t]` and falls by one on `req_done[t]`. Both together leave it unchanged. A completion at zero is ignored, and an issue at `MAX_INFLIGHT` is ignored.
- R8: A thread whose likelihood is 1.0 has `req_allow` low whatever its outstanding count.
- R9: Activations and requests of one thread never change another thread's likelihood or allow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | An activation was issued this cycle |
| act_thread | input | TID_W | Thread that caused the activation |
| act_bank | input | BANK_W | Bank of the activation |
| act_blacklisted | input | 1 | Target row is on the blacklist |
| epoch_tick | input | 1 | Epoch boundary: swap and clear the counter pairs |
| req_issue | input | NUM_THREADS | Per-thread request issued |
| req_done | input | NUM_THREADS | Per-thread request completed |
| req_allow | output | NUM_THREADS | Per-thread permission to issue a new request |
| likelihood | output | NUM_THREADS*(FRAC_W+1) | Per-thread fixed-point likelihood, for software |

## Verification
The assertions check the following on every cycle:
- counter saturation and the bound on the index;
- the single-step increments of the counters and of the outstanding count;
- the clearing of the read-side counter on a tick;
- full blocking at an index of one;
- the unrestricted allow at an index of zero.

Only the bench's scenarios show the following:
- the exact normalization of a non-power-of-two maximum;
- that the peak, rather than a sum, is taken over banks;
- the one-epoch history window produced by two ticks in a row;
- the handling of an activation that arrives together with a tick;
- that dropped completions and dropped issues leave no trace in later allow decisions.

The bench checks these against a reference model that it computes on its own.

// File: rtl/hammer_throttle_pkg.sv
package hammer_throttle_pkg;

   // Index width that stays at least one bit wide for single-entry sets.
   function automatic int unsigned safe_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/ht_pair_counter.sv
module ht_pair_counter #(
   parameter int unsigned MAX_ACTS = 20,
   parameter int unsigned CNT_W    = $clog2(MAX_ACTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             tick,
   input  logic             rd_sel,
   output logic [CNT_W-1:0] rd_cnt
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ACTS);

   logic [CNT_W-1:0] cnt0, cnt1;
   logic             clr0, clr1;

   assign clr0 = tick && !rd_sel;
   assign clr1 = tick &&  rd_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt0 <= '0;
         cnt1 <= '0;
      end else begin
         if (clr0)                   cnt0 <= '0;
         else if (hit && cnt0 < CAP) cnt0 <= cnt0 + CNT_W'(1);
         if (clr1)                   cnt1 <= '0;
         else if (hit && cnt1 < CAP) cnt1 <= cnt1 + CNT_W'(1);
      end
   end

   assign rd_cnt = rd_sel ? cnt1 : cnt0;

   p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt0 <= CAP) && (cnt1 <= CAP));

   p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !tick && cnt0 < CAP) |=> (cnt0 == $past(cnt0) + CNT_W'(1)));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !rd_sel) |=> (cnt0 == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !tick) |=> $stable(cnt1));
endmodule

// File: rtl/ht_thread_gate.sv
module ht_thread_gate import hammer_throttle_pkg::*; #(
   parameter int unsigned MAX_ACTS     = 20,
   parameter int unsigned FRAC_W       = 8,
   parameter int unsigned MAX_INFLIGHT = 8,
   parameter int unsigned CNT_W        = $clog2(MAX_ACTS + 1),
   parameter int unsigned IDX_W        = FRAC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] peak_cnt,
   input  logic             issue,
   input  logic             done,
   output logic [IDX_W-1:0] idx,
   output logic             allow
);
   localparam int unsigned OUT_W  = $clog2(MAX_INFLIGHT + 1);
   localparam int unsigned PROD_W = OUT_W + IDX_W;
   localparam int unsigned NUM_W  = CNT_W + FRAC_W;
   localparam int unsigned LOG2_M = $clog2(MAX_ACTS);
   localparam logic [IDX_W-1:0] ONE    = IDX_W'(1) << FRAC_W;
   localparam logic [OUT_W-1:0] CEIL_Q = OUT_W'(MAX_INFLIGHT);

   // Normalization: a shift when the maximum is a power of two, else a divide by a constant.
   generate
      if (is_pow2(MAX_ACTS) && (LOG2_M <= FRAC_W)) begin : g_shift
         assign idx = IDX_W'(peak_cnt) << (FRAC_W - LOG2_M);
      end else begin : g_div
         logic [NUM_W-1:0] numer;
         assign numer = {peak_cnt, {FRAC_W{1'b0}}};
         assign idx   = IDX_W'(numer / NUM_W'(MAX_ACTS));
      end
   endgenerate

   logic [PROD_W-1:0] prod;
   logic [OUT_W-1:0]  quota;
   logic [OUT_W-1:0]  outstanding;

   assign prod  = PROD_W'(MAX_INFLIGHT) * PROD_W'(ONE - idx);
   assign quota = OUT_W'(prod >> FRAC_W);
   assign allow = outstanding < quota;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outstanding <= '0;
      end else if (issue && !done && outstanding < CEIL_Q) begin
         outstanding <= outstanding + OUT_W'(1);
      end else if (done && !issue && outstanding != '0) begin
         outstanding <= outstanding - OUT_W'(1);
      end
   end

   p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= ONE);

   p_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == ONE) |-> !allow);

   p_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == '0 && outstanding < CEIL_Q) |-> allow);

   p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CEIL_Q);

   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !done && outstanding < CEIL_Q) |=> (outstanding == $past(outstanding) + OUT_W'(1)));
endmodule

// File: rtl/hammer_throttle.sv
module hammer_throttle import hammer_throttle_pkg::*; #(
   parameter  int unsigned NUM_THREADS  = 4,
   parameter  int unsigned NUM_BANKS    = 4,
   parameter  int unsigned MAX_ACTS     = 20,
   parameter  int unsigned FRAC_W       = 8,
   parameter  int unsigned MAX_INFLIGHT = 8,
   localparam int unsigned TID_W        = safe_w(NUM_THREADS),
   localparam int unsigned BANK_W       = safe_w(NUM_BANKS),
   localparam int unsigned IDX_W        = FRAC_W + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         act_valid,
   input  logic [TID_W-1:0]             act_thread,
   input  logic [BANK_W-1:0]            act_bank,
   input  logic                         act_blacklisted,
   input  logic                         epoch_tick,
   input  logic [NUM_THREADS-1:0]       req_issue,
   input  logic [NUM_THREADS-1:0]       req_done,
   output logic [NUM_THREADS-1:0]       req_allow,
   output logic [NUM_THREADS*IDX_W-1:0] likelihood
);
   localparam int unsigned CNT_W = $clog2(MAX_ACTS + 1);

   if (NUM_THREADS < 1) begin : g_chk_thr
      $error("NUM_THREADS must be at least 1");
   end
   if (NUM_BANKS < 1) begin : g_chk_bank
      $error("NUM_BANKS must be at least 1");
   end
   if (MAX_ACTS < 1) begin : g_chk_acts
      $error("MAX_ACTS must be at least 1");
   end
   if (MAX_INFLIGHT < 1) begin : g_chk_infl
      $error("MAX_INFLIGHT must be at least 1");
   end
   if (FRAC_W < 1) begin : g_chk_frac
      $error("FRAC_W must be at least 1");
   end

   logic rd_sel;

   always_ff @(posedge clk) begin
      if (!rst_n)          rd_sel <= 1'b0;
      else if (epoch_tick) rd_sel <= ~rd_sel;
   end

   logic [CNT_W-1:0] rd_cnt [NUM_THREADS][NUM_BANKS];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         assign hit = act_valid && act_blacklisted &&
                      (act_thread == TID_W'(t)) && (act_bank == BANK_W'(b));
         ht_pair_counter #(
            .MAX_ACTS (MAX_ACTS),
            .CNT_W    (CNT_W)
         ) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit),
            .tick   (epoch_tick),
            .rd_sel (rd_sel),
            .rd_cnt (rd_cnt[t][b])
         );
      end

      logic [CNT_W-1:0] peak;
      always_comb begin
         peak = '0;
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_cnt[t][b] > peak) peak = rd_cnt[t][b];
         end
      end

      ht_thread_gate #(
         .MAX_ACTS     (MAX_ACTS),
         .FRAC_W       (FRAC_W),
         .MAX_INFLIGHT (MAX_INFLIGHT),
         .CNT_W        (CNT_W),
         .IDX_W        (IDX_W)
      ) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .peak_cnt (peak),
         .issue    (req_issue[t]),
         .done     (req_done[t]),
         .idx      (likelihood[t*IDX_W +: IDX_W]),
         .allow    (req_allow[t])
      );
   end

   p_sel_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      epoch_tick |=> (rd_sel != $past(rd_sel)));
endmodule

// File: tb/hammer_throttle_test.sv
module hammer_throttle_test;
   localparam int T    = 4;
   localparam int B    = 4;
   localparam int MAXA = 20;
   localparam int FW   = 8;
   localparam int MAXI = 8;
   localparam int IW   = FW + 1;
   localparam int ONE  = 1 << FW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         act_valid = 1'b0;
   logic [1:0]   act_thread = '0;
   logic [1:0]   act_bank = '0;
   logic         act_blacklisted = 1'b0;
   logic         epoch_tick = 1'b0;
   logic [T-1:0] req_issue = '0;
   logic [T-1:0] req_done = '0;
   logic [T-1:0] req_allow;
   logic [T*IW-1:0] likelihood;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   hammer_throttle #(
      .NUM_THREADS(T), .NUM_BANKS(B), .MAX_ACTS(MAXA), .FRAC_W(FW), .MAX_INFLIGHT(MAXI)
   ) uut (
      .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_thread(act_thread),
      .act_bank(act_bank), .act_blacklisted(act_blacklisted), .epoch_tick(epoch_tick),
      .req_issue(req_issue), .req_done(req_done), .req_allow(req_allow), .likelihood(likelihood)
   );

   // Reference model
   int m_cnt [2][T][B];
   int m_sel;
   int m_out [T];

   function automatic int exp_idx(input int t);
      int pk = 0;
      for (int b = 0; b < B; b++) if (m_cnt[m_sel][t][b] > pk) pk = m_cnt[m_sel][t][b];
      return (pk * ONE) / MAXA;
   endfunction

   function automatic int exp_allow(input int t);
      int q = (MAXI * (ONE - exp_idx(t))) >> FW;
      return (m_out[t] < q) ? 1 : 0;
   endfunction

   function automatic int got_idx(input int t);
      return int'(likelihood[t*IW +: IW]);
   endfunction

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
      end
   endtask

   task automatic model_update();
      for (int t = 0; t < T; t++) begin
         if (req_issue[t] && !req_done[t] && m_out[t] < MAXI) m_out[t]++;
         else if (req_done[t] && !req_issue[t] && m_out[t] > 0) m_out[t]--;
      end
      for (int s = 0; s < 2; s++) begin
         if (epoch_tick && s == m_sel) begin
            for (int t = 0; t < T; t++) for (int b = 0; b < B; b++) m_cnt[s][t][b] = 0;
         end else if (act_valid && act_blacklisted) begin
            if (m_cnt[s][act_thread][act_bank] < MAXA) m_cnt[s][act_thread][act_bank]++;
         end
      end
      if (epoch_tick) m_sel ^= 1;
   endtask

   // One clock: model follows the edge, outputs are compared at the falling edge.
   task automatic cycle();
      @(posedge clk);
      if (rst_n) model_update();
      @(negedge clk);
      for (int t = 0; t < T; t++) begin
         check("R4 index", got_idx(t), exp_idx(t));
         check("R6 allow", int'(req_allow[t]), exp_allow(t));
      end
      act_valid = 0; act_blacklisted = 0; epoch_tick = 0;
      req_issue = '0; req_done = '0;
   endtask

   task automatic act(input int t, input int b, input int bl, input int n);
      for (int i = 0; i < n; i++) begin
         act_valid = 1; act_thread = 2'(t); act_bank = 2'(b); act_blacklisted = bl[0];
         cycle();
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      m_sel = 0;
      for (int s = 0; s < 2; s++) for (int t = 0; t < T; t++) for (int b = 0; b < B; b++) m_cnt[s][t][b] = 0;
      for (int t = 0; t < T; t++) m_out[t] = 0;

      repeat (3) @(negedge clk);
      for (int t = 0; t < T; t++) begin
         check("R1 reset index", got_idx(t), 0);
         check("R1 reset allow", int'(req_allow[t]), 1);
      end
      rst_n = 1;

      // R2, R4: five blacklisted hits on thread 1 bank 2 -> 5*256/20 = 64
      act(1, 2, 1, 5);
      check("R4 t1 index 64", got_idx(1), 64);
      check("R9 t0 untouched", got_idx(0), 0);
      act(1, 2, 0, 3);
      act_valid = 0; act_blacklisted = 1; act_thread = 2'd1; act_bank = 2'd2; cycle();
      check("R2 ignored activations", got_idx(1), 64);
      // R4 peak, not sum: two hits on another bank leave the index unchanged
      act(1, 0, 1, 2);
      check("R4 peak over banks", got_idx(1), 64);

      // R6: quota for index 64 is 8*192/256 = 6
      for (int i = 0; i < 6; i++) begin
         check("R6 allow below quota", int'(req_allow[1]), 1);
         req_issue[1] = 1; cycle();
      end
      check("R6 blocked at quota", int'(req_allow[1]), 0);
      req_issue[1] = 1; req_done[1] = 1; cycle();
      check("R7 issue plus done keeps count", int'(req_allow[1]), 0);
      req_done[1] = 1; cycle();
      check("R6 reopens after completion", int'(req_allow[1]), 1);

      // R7: completions at zero dropped, issues beyond ceiling dropped (thread 3, index 0)
      for (int i = 0; i < 3; i++) begin req_done[3] = 1; cycle(); end
      for (int i = 0; i < 7; i++) begin req_issue[3] = 1; cycle(); end
      check("R7 done at zero ignored", int'(req_allow[3]), 1);
      for (int i = 0; i < 3; i++) begin req_issue[3] = 1; cycle(); end
      check("R7 ceiling reached", int'(req_allow[3]), 0);
      req_done[3] = 1; cycle();
      check("R7 issue at ceiling ignored", int'(req_allow[3]), 1);
      for (int i = 0; i < 7; i++) begin req_done[3] = 1; cycle(); end

      // R3, R8: saturate thread 0 bank 3
      act(0, 3, 1, MAXA + 5);
      check("R3 index capped at one", got_idx(0), ONE);
      check("R8 full block", int'(req_allow[0]), 0);

      // R5: first tick keeps history, activation with tick counts only on survivor
      act_valid = 1; act_thread = 2'd2; act_bank = 2'd1; act_blacklisted = 1; epoch_tick = 1;
      cycle();
      check("R5 first tick keeps index", got_idx(0), ONE);
      check("R5 coincident hit counted", got_idx(2), 12);
      act(2, 1, 1, 2);
      epoch_tick = 1; cycle();
      check("R5 second tick drops old epoch", got_idx(0), 0);
      check("R5 new epoch window", got_idx(2), 25);
      check("R8 release after clear", int'(req_allow[0]), 1);

      // Constrained random traffic
      for (int k = 0; k < 3000; k++) begin
         act_valid       = ($urandom % 2) == 0;
         act_thread      = 2'($urandom % T);
         act_bank        = 2'($urandom % B);
         act_blacklisted = ($urandom % 3) == 0;
         epoch_tick      = ($urandom % 150) == 0;
         for (int t = 0; t < T; t++) begin
            req_issue[t] = (($urandom % 3) == 0) && (req_allow[t] || ($urandom % 8) == 0);
            req_done[t]  = ($urandom % 4) == 0;
         end
         cycle();
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule